// File: doc/BRIEF.md
# Vertical Line-Rate Conversion Sequencer

This block is the control half of a vertical scaler that turns 288-line luma and 144-line chroma pictures into 480-line interlaced frames, delivered as two fields of 240 lines each. The multiply-accumulate filter and the frame store sit outside it. Each strobe on `lineStart` opens one filter slot. For every slot the block decides four things. It decides whether a new luma line is pushed into the six-stage line-delay chain that feeds the seven-tap filter. It makes the same decision for a new chroma line. It picks the luma and chroma coefficient sets that the filter uses. It decides whether the filtered result is kept as an output line.

Luma runs as up-by-five, down-by-three. Three source lines yield five output lines, and the luma phase steps by three modulo five. Chroma pushes a line on every second slot, so each source chroma line is fetched twice by the memory side. Each push yields two filtered slots. One slot in every six is thrown away, so six slots give five kept lines. Luma holds still on the thrown-away slot. A pulse on `fieldStart` restarts both sequences and latches the field parity. The parity picks the lower or upper bank of five coefficient sets for the whole field.

Top module: `vert_rate_ctrl`

## Requirements
- R1: After reset, `outValid`, `lumaRead` and `chromaRead` are 0, and `lumaSet` and `chromaSet` are 0.
- R2: A `lineStart` taken in one cycle shows its results on the outputs after the next clock edge. `outValid`, `lumaRead` and `chromaRead` are single-cycle pulses and are 0 in any cycle that does not follow an accepted `lineStart`.
- R3: Slots are numbered s = 0, 1, 2 … from the last `fieldStart`. Slot s has `outValid` = 0 when s mod 6 = 5, and `outValid` = 1 otherwise.
- R4: On the k-th kept slot of a field (k counted from 0), `lumaSet` = bank + (3k mod 5). The five phases therefore run in the order 0, 3, 1, 4, 2.
- R5: `lumaRead` pulses on a kept slot exactly when its luma phase (3k mod 5) is 0, 1 or 2. It never pulses on a discarded slot.
- R6: `chromaRead` pulses on slot s exactly when s mod 6 is 0, 2 or 4.
- R7: On a kept slot, `chromaSet` = bank + (s mod 6). On a discarded slot, both `lumaSet` and `chromaSet` keep their previous values.
- R8: The bank is 0 when `fieldOdd` was 0 at the `fieldStart`, and 5 when it was 1. A change of `fieldOdd` inside the field does not alter any set index.
- R9: `fieldStart` restarts slot and phase counting from zero. A `lineStart` in the same cycle is ignored and produces no pulse.
- R10: A field of 288 slots yields 240 `outValid` pulses, 144 `lumaRead` pulses and 144 `chromaRead` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fieldStart | input | 1 | Field restart strobe; latches parity |
| fieldOdd | input | 1 | Field parity, sampled on fieldStart |
| lineStart | input | 1 | One filter slot per pulse |
| lumaRead | output | 1 | Push a new luma line into the delay chain |
| chromaRead | output | 1 | Push a new chroma line into the delay chain |
| lumaSet | output | 4 | Luma coefficient set index, 0 to 9 |
| chromaSet | output | 4 | Chroma coefficient set index, 0 to 9 |
| outValid | output | 1 | Filtered line is kept as an output line |

## Verification
The bench runs whole fields of both parities, with both back-to-back and spaced slots. It compares every slot with an arithmetic model of the two sequences.

- **Luma wrap.** A phase that wrapped wrongly would leave the 0, 3, 1, 4, 2 order or miscount luma pushes against the expected 144.
- **Discard slot.** A design that advanced luma on the discarded slot would drift by one phase every six slots. A design that moved the set indices on that slot would break the hold rule.
- **Parity.** Parity is toggled inside a field, which catches a design that follows the live parity pin instead of the latched value.
- **Mid-field restart.** A restart that coincides with a line strobe checks that the strobe is swallowed and that counting resumes from slot 0.

// File: rtl/vrc_pkg.sv
package vrc_pkg;
  // Per-slot decisions passed from control to datapath
  typedef struct packed {
    logic advance;    // a slot is being processed this cycle
    logic keep;       // filtered line is retained
    logic lumaRead;   // luma delay chain advances
    logic chromaRead; // chroma delay chain advances
  } vrcStrobe_t;
endpackage

// File: rtl/vrc_ctrl.sv
module vrc_ctrl
  import vrc_pkg::*;
#(
  parameter int PHASES = 5,
  parameter int STEP   = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic fieldStart,
  input  logic fieldOdd,
  input  logic lineStart,
  output vrcStrobe_t strb,
  output logic [$clog2(PHASES)-1:0]   lumaPhase,
  output logic [$clog2(PHASES+1)-1:0] slotPos,
  output logic bankOdd
);
  localparam int GROUP = PHASES + 1;
  localparam int PHW   = $clog2(PHASES);
  localparam int POSW  = $clog2(GROUP);

  logic [PHW:0] phaseSum;
  logic         lastPos;

  assign lastPos  = (slotPos == POSW'(GROUP - 1));
  assign phaseSum = {1'b0, lumaPhase} + (PHW+1)'(STEP);

  always_comb begin
    strb.advance    = lineStart && !fieldStart;
    strb.keep       = !lastPos;
    strb.lumaRead   = !lastPos && (lumaPhase < PHW'(STEP));
    strb.chromaRead = !slotPos[0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      slotPos   <= '0;
      lumaPhase <= '0;
      bankOdd   <= 1'b0;
    end else if (fieldStart) begin
      slotPos   <= '0;
      lumaPhase <= '0;
      bankOdd   <= fieldOdd;
    end else if (lineStart) begin
      slotPos <= lastPos ? '0 : slotPos + 1'b1;
      if (!lastPos) begin
        if (phaseSum >= (PHW+1)'(PHASES))
          lumaPhase <= PHW'(phaseSum - (PHW+1)'(PHASES));
        else
          lumaPhase <= PHW'(phaseSum);
      end
    end
  end
endmodule

// File: rtl/vrc_datapath.sv
module vrc_datapath
  import vrc_pkg::*;
#(
  parameter int PHASES = 5,
  parameter int SETW   = 4
) (
  input  logic clk,
  input  logic rstN,
  input  vrcStrobe_t strb,
  input  logic [$clog2(PHASES)-1:0]   lumaPhase,
  input  logic [$clog2(PHASES+1)-1:0] slotPos,
  input  logic bankOdd,
  output logic lumaRead,
  output logic chromaRead,
  output logic [SETW-1:0] lumaSet,
  output logic [SETW-1:0] chromaSet,
  output logic outValid
);
  logic [SETW-1:0] bankOff;
  assign bankOff = bankOdd ? SETW'(PHASES) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lumaRead   <= 1'b0;
      chromaRead <= 1'b0;
      outValid   <= 1'b0;
      lumaSet    <= '0;
      chromaSet  <= '0;
    end else begin
      lumaRead   <= strb.advance && strb.lumaRead;
      chromaRead <= strb.advance && strb.chromaRead;
      outValid   <= strb.advance && strb.keep;
      if (strb.advance && strb.keep) begin
        lumaSet   <= bankOff + SETW'(lumaPhase);
        chromaSet <= bankOff + SETW'(slotPos);
      end
    end
  end
endmodule

// File: rtl/vert_rate_ctrl.sv
module vert_rate_ctrl
  import vrc_pkg::*;
#(
  parameter int PHASES = 5,
  parameter int STEP   = 3,
  parameter int SETW   = $clog2(2 * PHASES)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            fieldStart,
  input  logic            fieldOdd,
  input  logic            lineStart,
  output logic            lumaRead,
  output logic            chromaRead,
  output logic [SETW-1:0] lumaSet,
  output logic [SETW-1:0] chromaSet,
  output logic            outValid
);
  vrcStrobe_t strb;
  logic [$clog2(PHASES)-1:0]   lumaPhase;
  logic [$clog2(PHASES+1)-1:0] slotPos;
  logic                        bankOdd;

  vrc_ctrl #(.PHASES(PHASES), .STEP(STEP)) uCtrl (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .fieldOdd(fieldOdd),
    .lineStart(lineStart), .strb(strb), .lumaPhase(lumaPhase),
    .slotPos(slotPos), .bankOdd(bankOdd)
  );

  vrc_datapath #(.PHASES(PHASES), .SETW(SETW)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .lumaPhase(lumaPhase),
    .slotPos(slotPos), .bankOdd(bankOdd), .lumaRead(lumaRead),
    .chromaRead(chromaRead), .lumaSet(lumaSet), .chromaSet(chromaSet),
    .outValid(outValid)
  );
endmodule

// File: rtl/vrc_checker.sv
module vrc_checker #(
  parameter int PHASES = 5,
  parameter int SETW   = 4
) (
  input logic            clk,
  input logic            rstN,
  input logic            fieldStart,
  input logic            lineStart,
  input logic            lumaRead,
  input logic            chromaRead,
  input logic [SETW-1:0] lumaSet,
  input logic [SETW-1:0] chromaSet,
  input logic            outValid
);
  // R2: every pulse traces back to an accepted slot strobe
  a_r2_pulse_needs_slot: assert property (@(posedge clk) disable iff (!rstN)
    (outValid || lumaRead || chromaRead) |-> $past(lineStart && !fieldStart));

  // R5: luma never advances on a discarded slot
  a_r5_luma_only_kept: assert property (@(posedge clk) disable iff (!rstN)
    lumaRead |-> outValid);

  // R7: set indices hold whenever no line is kept
  a_r7_hold_on_drop: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(lumaSet) && $stable(chromaSet)));

  // R8: luma and chroma always come from the same bank
  a_r8_same_bank: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ((lumaSet >= SETW'(PHASES)) == (chromaSet >= SETW'(PHASES))));

  // R4: index stays inside the two banks
  a_r4_set_range: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (lumaSet < SETW'(2 * PHASES)));
endmodule

bind vert_rate_ctrl vrc_checker #(.PHASES(PHASES), .SETW(SETW)) uChk (
  .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .lineStart(lineStart),
  .lumaRead(lumaRead), .chromaRead(chromaRead), .lumaSet(lumaSet),
  .chromaSet(chromaSet), .outValid(outValid)
);

// File: tb/sim_vert_rate_ctrl.sv
`timescale 1ns/1ps
module sim_vert_rate_ctrl;
  logic clk = 0;
  logic rstN = 0;
  logic fieldStart = 0;
  logic fieldOdd = 0;
  logic lineStart = 0;
  logic lumaRead, chromaRead, outValid;
  logic [3:0] lumaSet, chromaSet;

  int nRun = 0;
  int nFail = 0;
  int s = 0, k = 0, bank = 0;
  int expL = 0, expC = 0;
  int cntValid = 0, cntL = 0, cntC = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  vert_rate_ctrl u0 (
    .clk(clk), .rstN(rstN), .fieldStart(fieldStart), .fieldOdd(fieldOdd),
    .lineStart(lineStart), .lumaRead(lumaRead), .chromaRead(chromaRead),
    .lumaSet(lumaSet), .chromaSet(chromaSet), .outValid(outValid)
  );

  task automatic chk(string tag, int act, int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic quiet(string tag);
    chk({tag, " outValid low"}, outValid, 0);
    chk({tag, " lumaRead low"}, lumaRead, 0);
    chk({tag, " chromaRead low"}, chromaRead, 0);
  endtask

  task automatic beginField(bit odd, bit withLine);
    fieldOdd = odd; fieldStart = 1; lineStart = withLine;
    @(negedge clk);
    fieldStart = 0; lineStart = 0;
    quiet("R9 restart swallows slot");
    chk("R9 set held at restart L", lumaSet, expL);
    s = 0; k = 0; bank = odd ? 5 : 0;
    cntValid = 0; cntL = 0; cntC = 0;
  endtask

  task automatic slot(int gap);
    bit keep;
    int ph, pos;
    lineStart = 1;
    @(negedge clk);
    lineStart = 0;
    pos  = s % 6;
    keep = (pos != 5);
    ph   = (3 * k) % 5;
    chk("R3 outValid", outValid, keep);
    chk("R6 chromaRead", chromaRead, (pos % 2) == 0);
    chk("R5 lumaRead", lumaRead, keep && ph < 3);
    if (keep) begin
      expL = bank + ph;
      expC = bank + pos;
    end
    chk("R4 R8 lumaSet", lumaSet, expL);
    chk("R7 R8 chromaSet", chromaSet, expC);
    cntValid += outValid; cntL += lumaRead; cntC += chromaRead;
    if (keep) k++;
    s++;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk);
      quiet("R2 idle");
    end
  endtask

  task automatic fullField(bit odd, int gapMode, bit flipMid);
    beginField(odd, 0);
    for (int i = 0; i < 288; i++) begin
      if (flipMid && i == 100) fieldOdd = !odd;
      slot((gapMode == 0) ? 0 : (i % 3));
    end
    chk("R10 kept lines per field", cntValid, 240);
    chk("R10 luma pushes per field", cntL, 144);
    chk("R10 chroma pushes per field", cntC, 144);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    quiet("R1 reset");
    chk("R1 lumaSet reset", lumaSet, 0);
    chk("R1 chromaSet reset", chromaSet, 0);
    rstN = 1;
    @(negedge clk);
    quiet("R2 no strobe");
    fullField(0, 0, 0);
    fullField(1, 1, 1);
    fullField(0, 1, 1);
    // mid-field restart with a coincident slot strobe
    beginField(0, 0);
    for (int i = 0; i < 17; i++) slot(0);
    beginField(1, 1);
    for (int i = 0; i < 40; i++) slot(1);
    fullField(1, 0, 0);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        nRun++; nFail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule